// File: doc/BRIEF.md
# Indirect Pattern RAM Access Port

This block puts a 128-word by 40-bit pattern RAM behind three 32-bit host registers. The host reaches the RAM through a control register and two data registers. The control register holds a word address, one RAM byte and a mode bit. The two data registers hold the other four RAM bytes. A read of any register returns the fields of the RAM word at the current address.

A write to the RAM only takes effect after a strict three-step sequence. The host writes the control register, then the low data register, then the high data register. The word is written only on that last step. Setting the mode bit gives the RAM to a pattern-matching engine. While the bit is set, the host can neither change nor observe the RAM, and the engine reads words through its own asynchronous port.

Top module: `patRamPort`

## Requirements
- R1: After reset the mode bit is 0, the word address is 0, and bits 7:0 of a control-register read are 0.
- R2: Register select 0 is the control register, 1 is the low data register and 2 is the high data register. With the mode bit at 0, writing select 0, then select 1, then select 2 stores a 40-bit word at the address in control bits 6:0. Byte 0 comes from control bits 15:8, bytes 1 and 2 from low-data bits 7:0 and 15:8, and bytes 3 and 4 from high-data bits 7:0 and 15:8. Reads of the three registers return those bytes in the same positions, and control bits 6:0 read back as the address.
- R3: The RAM word is unchanged after the control and low-data writes, until the high-data write arrives.
- R4: A high-data write that does not directly follow a sequenced low-data write leaves the RAM unchanged. A low-data write that does not directly follow an accepted control write does not count as a sequence step.
- R5: While the mode bit is 1, a control read returns 0x00000080 and data-register reads return 0.
- R6: While the mode bit is 1, data-register writes are ignored. A control write changes only the mode bit, so the address and RAM are the same after the mode is cleared.
- R7: While the mode bit is 1, the engine port returns the RAM word at the engine address, with byte 0 in bits 7:0. While the mode bit is 0, the engine port returns 0.
- R8: Bits 31:16 of every read are 0, and a read of select 3 returns 0.
- R9: Register reads between sequence steps do not break the write sequence.
- R10: A control write with bit 7 set changes only the mode bit. The address and the staged byte 0 keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSel | input | 2 | Register select (0 control, 1 low data, 2 high data, 3 unused) |
| wrEn | input | 1 | Write strobe for the selected register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data of the selected register (combinational) |
| matchMode | output | 1 | Current mode bit |
| engAddr | input | 7 | Engine read address |
| engData | output | 40 | Engine read data |

## Verification
The bench goes after broken write sequences: a high-data write with no low-data step, and a low-data write that lacks a fresh control write. A design that commits on any high-data write would overwrite the word. It also checks that the word is unchanged after the control and low-data writes, which catches a design that writes each byte to the RAM as it arrives. Both directions of mode entry are covered. A control write with bit 7 set, or any write made while in match mode, must not move the address, and reads in match mode must hide every RAM byte. A design that leaks state here would read back the wrong word or expose data. Reads placed between sequence steps expose a design that resets its sequence tracker on reads.

// File: rtl/patRamPkg.sv
package patRamPkg;
  localparam int ADDR_W = 7;
  localparam int BYTES  = 5;
  localparam int WORD_W = BYTES * 8;
  localparam int REG_W  = 32;
  localparam int MODE_BIT = 7;

  typedef enum logic [1:0] {
    SEL_CTRL = 2'd0,
    SEL_LO   = 2'd1,
    SEL_HI   = 2'd2,
    SEL_NONE = 2'd3
  } regSel_e;

  typedef struct packed {
    logic ldCtrl;   // latch address and byte 0
    logic ldLo;     // latch bytes 1..2
    logic commit;   // write full word to RAM
  } strobe_t;
endpackage

// File: rtl/patRamCtrl.sv
module patRamCtrl
  import patRamPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] regSel,
  input  logic       wrModeBit,
  output strobe_t    strb,
  output logic       matchMode
);
  typedef enum logic [1:0] {ST_IDLE, ST_HAVE_CTRL, ST_HAVE_LO} seq_e;
  seq_e seqQ, seqD;
  logic ldMode;

  always_comb begin
    strb   = '0;
    ldMode = 1'b0;
    if (wrEn) begin
      unique case (regSel)
        SEL_CTRL: begin
          ldMode      = 1'b1;
          strb.ldCtrl = !matchMode && !wrModeBit;
        end
        SEL_LO:   strb.ldLo   = !matchMode && (seqQ == ST_HAVE_CTRL);
        SEL_HI:   strb.commit = !matchMode && (seqQ == ST_HAVE_LO);
        default:  ;
      endcase
    end
  end

  always_comb begin
    seqD = seqQ;
    if (wrEn) begin
      if (strb.ldCtrl)    seqD = ST_HAVE_CTRL;
      else if (strb.ldLo) seqD = ST_HAVE_LO;
      else                seqD = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seqQ      <= ST_IDLE;
      matchMode <= 1'b0;
    end else begin
      seqQ <= seqD;
      if (ldMode) matchMode <= wrModeBit;
    end
  end
endmodule

// File: rtl/patRamDp.sv
module patRamDp
  import patRamPkg::*;
#(
  parameter int AW = ADDR_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              matchMode,
  input  logic [1:0]        regSel,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  input  logic [AW-1:0]     engAddr,
  output logic [WORD_W-1:0] engData
);
  localparam int DEPTH = 1 << AW;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     addrQ;
  logic [7:0]        byte0Q;
  logic [15:0]       loBytesQ;
  logic [WORD_W-1:0] curWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      byte0Q   <= '0;
      loBytesQ <= '0;
    end else begin
      if (strb.ldCtrl) begin
        addrQ  <= wrData[AW-1:0];
        byte0Q <= wrData[15:8];
      end
      if (strb.ldLo) loBytesQ <= wrData[15:0];
    end
  end

  always_ff @(posedge clk) begin
    if (strb.commit) mem[addrQ] <= {wrData[15:0], loBytesQ, byte0Q};
  end

  assign curWord = mem[addrQ];
  assign engData = matchMode ? mem[engAddr] : '0;

  always_comb begin
    rdData = '0;
    if (matchMode) begin
      if (regSel == SEL_CTRL) rdData[MODE_BIT] = 1'b1;
    end else begin
      unique case (regSel)
        SEL_CTRL: begin
          rdData[15:8]   = curWord[7:0];
          rdData[AW-1:0] = addrQ;
        end
        SEL_LO:  rdData[15:0] = curWord[23:8];
        SEL_HI:  rdData[15:0] = curWord[39:24];
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/patRamPort.sv
module patRamPort
  import patRamPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regSel,
  input  logic              wrEn,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic              matchMode,
  input  logic [6:0]        engAddr,
  output logic [39:0]       engData
);
  strobe_t strb;

  patRamCtrl uCtrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regSel(regSel),
    .wrModeBit(wrData[MODE_BIT]), .strb(strb), .matchMode(matchMode)
  );

  patRamDp #(.AW(ADDR_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .matchMode(matchMode),
    .regSel(regSel), .wrData(wrData), .rdData(rdData),
    .engAddr(engAddr), .engData(engData)
  );
endmodule

// File: rtl/patRamChk.sv
module patRamChk (
  input logic        clk,
  input logic        rstN,
  input logic [1:0]  regSel,
  input logic        wrEn,
  input logic [31:0] rdData,
  input logic        matchMode,
  input logic [6:0]  engAddr,
  input logic [39:0] engData
);
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    rdData[31:16] == 16'h0);  // R8
  AST_MODE_CTRL_READ: assert property (@(posedge clk) disable iff (!rstN)
    (matchMode && regSel == 2'd0) |-> rdData == 32'h80);  // R5
  AST_MODE_DATA_HIDDEN: assert property (@(posedge clk) disable iff (!rstN)
    (matchMode && regSel != 2'd0) |-> rdData == 32'h0);  // R5
  AST_ENG_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !matchMode |-> engData == 40'h0);  // R7
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (matchMode && wrEn && regSel != 2'd0) |=> matchMode);  // R6
  AST_NO_HOST_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    (matchMode && wrEn && regSel != 2'd0) |=> (!$stable(engAddr) || $stable(engData)));  // R6
endmodule

bind patRamPort patRamChk uChk (
  .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .rdData(rdData),
  .matchMode(matchMode), .engAddr(engAddr), .engData(engData)
);

// File: tb/tb_patRamPort.sv
module tb_patRamPort;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  regSel = 2'd3;
  logic        wrEn = 1'b0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic        matchMode;
  logic [6:0]  engAddr = '0;
  logic [39:0] engData;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [39:0] model [128];

  always #4 clk = ~clk;  // 125 MHz

  patRamPort dut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .matchMode(matchMode), .engAddr(engAddr), .engData(engData)
  );

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    @(negedge clk);
    regSel = sel; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; regSel = 2'd3;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [31:0] d);
    @(negedge clk);
    regSel = sel;
    #1 d = rdData;
  endtask

  function automatic logic [39:0] pat(input int i);
    logic [7:0] b = 8'(i);
    return {b ^ 8'hA5, b + 8'd3, ~b, b ^ 8'h5A, b + 8'h71};
  endfunction

  task automatic writeWord(input int a, input logic [39:0] w);
    wr(2'd0, {16'h0, w[7:0], 1'b0, 7'(a)});
    wr(2'd1, {16'h0, w[23:8]});
    wr(2'd2, {16'h0, w[39:24]});
    model[a] = w;
  endtask

  task automatic expectWord(input int a, input string req);
    logic [31:0] c, l, h;
    wr(2'd0, {16'h0, model[a][7:0], 1'b0, 7'(a)});
    rd(2'd0, c); rd(2'd1, l); rd(2'd2, h);
    check(c == {16'h0, model[a][7:0], 1'b0, 7'(a)}, req, 64'(c), 64'({model[a][7:0], 1'b0, 7'(a)}));
    check(l == {16'h0, model[a][23:8]}, req, 64'(l), 64'(model[a][23:8]));
    check(h == {16'h0, model[a][39:24]}, req, 64'(h), 64'(model[a][39:24]));
  endtask

  task automatic testReset();
    logic [31:0] c;
    rd(2'd0, c);
    check(matchMode == 1'b0, "R1 mode", 64'(matchMode), 64'd0);
    check(c[7:0] == 8'h0, "R1 ctrl low", 64'(c[7:0]), 64'd0);
    check(c[31:16] == 16'h0, "R8 upper", 64'(c[31:16]), 64'd0);
  endtask

  task automatic testFill();
    for (int i = 0; i < 128; i++) writeWord(i, pat(i));
    expectWord(0, "R2 word0");
    expectWord(77, "R2 word77");
    expectWord(127, "R2 word127");
    writeWord(12, 40'h11_2233_4455);
    expectWord(12, "R2 bytes");
  endtask

  task automatic testStaging();
    logic [31:0] h;
    wr(2'd0, {16'h0, 8'hEE, 8'd40});
    wr(2'd1, 32'h0000_DDCC);
    rd(2'd2, h);
    check(h == {16'h0, model[40][39:24]}, "R3 no early write", 64'(h), 64'(model[40][39:24]));
    wr(2'd2, 32'h0000_BBAA);
    model[40] = 40'hBBAA_DDCC_EE;
    expectWord(40, "R3 commit");
  endtask

  task automatic testBadSeq();
    wr(2'd0, {16'h0, 8'h99, 8'd50});
    wr(2'd2, 32'h0000_1234);
    expectWord(50, "R4 hi without lo");
    writeWord(51, 40'h01_0203_0405);
    wr(2'd1, 32'h0000_7777);
    wr(2'd2, 32'h0000_8888);
    expectWord(51, "R4 lo without ctrl");
  endtask

  task automatic testReadsInSeq();
    logic [31:0] t;
    wr(2'd0, {16'h0, 8'h42, 8'd60});
    rd(2'd1, t);
    wr(2'd1, 32'h0000_5566);
    rd(2'd0, t);
    rd(2'd3, t);
    check(t == 32'h0, "R8 sel3", 64'(t), 64'd0);
    wr(2'd2, 32'h0000_7788);
    model[60] = 40'h7788_5566_42;
    expectWord(60, "R9 reads between steps");
  endtask

  task automatic testMode();
    logic [31:0] t;
    wr(2'd0, {16'h0, model[20][7:0], 8'd20});
    wr(2'd0, {16'h0, 8'hFF, 8'h80 | 8'd99});
    check(matchMode == 1'b1, "R10 mode set", 64'(matchMode), 64'd1);
    rd(2'd0, t); check(t == 32'h80, "R5 ctrl read", 64'(t), 64'h80);
    rd(2'd1, t); check(t == 32'h0, "R5 lo read", 64'(t), 64'h0);
    rd(2'd2, t); check(t == 32'h0, "R5 hi read", 64'(t), 64'h0);
    for (int a = 0; a < 128; a += 37) begin
      @(negedge clk); engAddr = 7'(a);
      #1 check(engData == model[a], "R7 engine read", 64'(engData), 64'(model[a]));
    end
    wr(2'd1, 32'h0000_ABAB);
    wr(2'd2, 32'h0000_CDCD);
    wr(2'd0, {16'h0, 8'h11, 8'd5});
    check(matchMode == 1'b0, "R6 mode cleared", 64'(matchMode), 64'd0);
    rd(2'd0, t);
    check(t == {16'h0, model[20][7:0], 8'd20}, "R6 R10 addr kept", 64'(t), 64'({model[20][7:0], 8'd20}));
    rd(2'd1, t);
    check(t == {16'h0, model[20][23:8]}, "R6 word kept", 64'(t), 64'(model[20][23:8]));
    #1 check(engData == 40'h0, "R7 engine idle", 64'(engData), 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    testFill();
    testStaging();
    testBadSeq();
    testReadsInSeq();
    testMode();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule